// File: doc/BRIEF.md
# Saturating Up/Down Counter Field

This block keeps a counter value in a single register field. Hardware bumps it with an increment pulse and a decrement pulse. Each pulse moves the value by its own step. A step is either fixed by a parameter or taken from an input port, and the width of that port is a parameter. Software reaches the same field through an already decoded write strobe and data word, so it can preset or clear the count. Counting up is always available. Counting down is enabled by a parameter, and both directions can be active together.

Each direction has its own limit mode:
- **Wrap.** The value wraps modulo 2^WIDTH, and an event output marks the cycle in which a pulse is about to wrap.
- **Edge.** The value saturates at the all-ones value going up, or at zero going down.
- **Fixed.** The value saturates at a parameter value.
- **Port.** The value saturates at a value taken from an input port.

In the three saturating modes the limit is enforced on every update, including software writes. It is also enforced on idle cycles, so a limit on a port that moves across the value pulls the value along.

Two threshold flags follow the registered count. One is high while the count is at or above an upper threshold. The other is high while the count is at or below a lower threshold. Each threshold is fixed or taken from a port. If both limits are enforced and they conflict, the lower limit wins.

Top module: `ctrfld_counter`

## Requirements
- R1: On a clock edge with `rst_n` low the count loads the parameter `RST_VAL`.
- R2: An `up_pulse` adds the increment step and a `dn_pulse` subtracts the decrement step. Each step is the parameter value when its source is `SRC_FIXED`, or the zero-extended port (`up_step` / `dn_step`) when its source is `SRC_PORT`.
- R3: With the up limit mode `LIM_WRAP`, a count result above 2^WIDTH-1 wraps modulo 2^WIDTH. `overflow` is high combinationally in the same cycle as the pulse that causes the wrap, and the wrapped value appears after the next edge.
- R4: With the down limit mode `LIM_WRAP`, a count result below 0 wraps modulo 2^WIDTH. `underflow` is high combinationally in the same cycle as the pulse that causes the wrap.
- R5: With the up limit mode `LIM_EDGE`, `LIM_FIXED` or `LIM_PORT`, the count clamps at 2^WIDTH-1, at `UP_LIM_VAL` or at `up_limit` respectively, and `overflow` never asserts.
- R6: With the down limit mode `LIM_EDGE`, `LIM_FIXED` or `LIM_PORT`, the count clamps at 0, at `DN_LIM_VAL` or at `dn_limit` respectively, and `underflow` never asserts.
- R7: The limits of R5 and R6 are applied on every clock. This covers written data and idle cycles after a port limit has moved past the count.
- R8: When both pulses arrive in one cycle, the count changes by the increment step minus the decrement step. Wrap or clamp is applied once, to that net result.
- R9: A software write (`sw_we` high) takes precedence over both pulses in the same cycle. The count becomes `sw_wdata`, subject to R7, and no overflow or underflow event is raised.
- R10: `at_or_above` is high while the count is at or above the upper threshold. That threshold is `UP_THR_VAL` (default 2^WIDTH-1) or the `up_thresh` port.
- R11: `at_or_below` is high while the count is at or below the lower threshold. That threshold is `DN_THR_VAL` (default 0) or the `dn_thresh` port.
- R12: With `DN_ENABLE` = 0, `dn_pulse` has no effect on the count or on `underflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_pulse | input | 1 | Increment request for this cycle |
| up_step | input | UP_STEP_W | Increment step when taken from the port |
| dn_pulse | input | 1 | Decrement request for this cycle |
| dn_step | input | DN_STEP_W | Decrement step when taken from the port |
| up_limit | input | WIDTH | Upper saturation value in port mode |
| dn_limit | input | WIDTH | Lower saturation value in port mode |
| up_thresh | input | WIDTH | Upper threshold when taken from the port |
| dn_thresh | input | WIDTH | Lower threshold when taken from the port |
| sw_we | input | 1 | Decoded software write strobe |
| sw_wdata | input | WIDTH | Software write data |
| count | output | WIDTH | Current counter value |
| at_or_above | output | 1 | Count is at or above the upper threshold |
| at_or_below | output | 1 | Count is at or below the lower threshold |
| overflow | output | 1 | An increment is about to wrap |
| underflow | output | 1 | A decrement is about to wrap |

## Verification
The bench drives written values beyond a port limit, and a port limit lowered beneath a held count. A design that clamped only on count pulses would leave those values out of range. It also issues simultaneous up and down pulses, both at a saturation edge and across the wrap point. A design that resolved each direction on its own would clamp or flag an event that the net change never reaches. A write coinciding with both pulses checks that the write wins. In a saturating configuration the bench checks that overflow and underflow stay silent. With down counting disabled it checks that a decrement pulse leaves the count alone.

// File: rtl/ctrfld_pkg.sv
// Shared types for the counter field: limit behaviour per direction and
// the source of a step or threshold value.
package ctrfld_pkg;
    typedef enum logic [1:0] {
        LIM_WRAP,   // wrap modulo 2^WIDTH and raise an event
        LIM_EDGE,   // saturate at the natural end (all ones, or zero)
        LIM_FIXED,  // saturate at a parameter value
        LIM_PORT    // saturate at a value taken from an input port
    } lim_mode_e;

    typedef enum logic {
        SRC_FIXED,
        SRC_PORT
    } src_sel_e;
endpackage

// File: rtl/ctrfld_src_sel.sv
// Chooses between a parameter constant and an input port for a value
// of width W. A port narrower than W is zero-extended.
// Assumes PW <= W. In fixed mode the port is intentionally left unused.
module ctrfld_src_sel
    import ctrfld_pkg::*;
#(
    parameter int unsigned W         = 8,
    parameter int unsigned PW        = 8,
    parameter src_sel_e    SRC       = SRC_FIXED,
    parameter int unsigned FIXED_VAL = 0
) (
    input  logic [PW-1:0] port_val,
    output logic [W-1:0]  sel_val
);
    generate
        if (SRC == SRC_PORT) begin : g_port
            // Pass the port through, widened to W.
            assign sel_val = W'(port_val);
        end else begin : g_fixed
            logic unused_port;
            // Drive the constant and park the port.
            assign unused_port = ^port_val;
            assign sel_val     = W'(FIXED_VAL);
        end
    endgenerate
endmodule

// File: rtl/ctrfld_next.sv
// Computes the next count from the current count, the step amounts
// already gated by their pulses, the write port and the limits.
// The arithmetic is done two bits wider and signed, so that both a carry
// past the top and a borrow below zero are visible. Upper handling comes
// first, then lower handling, so the lower limit wins a conflict.
// Assumes the step amounts are at most 2^WIDTH-1.
module ctrfld_next
    import ctrfld_pkg::*;
#(
    parameter int unsigned WIDTH   = 8,
    parameter lim_mode_e   UP_MODE = LIM_EDGE,
    parameter lim_mode_e   DN_MODE = LIM_EDGE
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] up_amt,
    input  logic [WIDTH-1:0] dn_amt,
    input  logic [WIDTH-1:0] hi_lim,
    input  logic [WIDTH-1:0] lo_lim,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] nxt,
    output logic             wrap_up,
    output logic             wrap_dn
);
    localparam int SW = WIDTH + 2;
    localparam logic signed [SW-1:0] SPAN_S = SW'(64'(1) << WIDTH);
    localparam logic signed [SW-1:0] MAX_S  = SPAN_S - 1;

    logic signed [SW-1:0] cand;
    logic signed [SW-1:0] wrk;
    logic [1:0]           unused_hi_bits;

    // Build the net candidate, then wrap or clamp it once in each direction.
    always_comb begin
        wrap_up = 1'b0;
        wrap_dn = 1'b0;
        if (wr_en) begin
            cand = $signed({2'b00, wr_data});
        end else begin
            cand = $signed({2'b00, cur}) + $signed({2'b00, up_amt})
                 - $signed({2'b00, dn_amt});
        end
        wrk = cand;
        if (UP_MODE == LIM_WRAP) begin
            if (wrk > MAX_S) begin
                wrk     = wrk - SPAN_S;
                wrap_up = 1'b1;
            end
        end else if (wrk > $signed({2'b00, hi_lim})) begin
            wrk = $signed({2'b00, hi_lim});
        end
        if (DN_MODE == LIM_WRAP) begin
            if (wrk < 0) begin
                wrk     = wrk + SPAN_S;
                wrap_dn = 1'b1;
            end
        end else if (wrk < $signed({2'b00, lo_lim})) begin
            wrk = $signed({2'b00, lo_lim});
        end
        nxt = wrk[WIDTH-1:0];
    end

    assign unused_hi_bits = wrk[SW-1:WIDTH];
endmodule

// File: rtl/ctrfld_counter.sv
// Counter field top level. It resolves the steps, limits and thresholds
// from parameters or ports, computes the next value and holds it in the
// count register. The overflow and underflow events are combinational
// and describe the update that the coming edge will make.
// Assumes UP_STEP_W and DN_STEP_W are at most WIDTH.
module ctrfld_counter
    import ctrfld_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned RST_VAL     = 0,
    parameter bit          DN_ENABLE   = 1'b1,
    parameter src_sel_e    UP_STEP_SRC = SRC_FIXED,
    parameter int unsigned UP_STEP_W   = 4,
    parameter int unsigned UP_STEP_VAL = 1,
    parameter src_sel_e    DN_STEP_SRC = SRC_FIXED,
    parameter int unsigned DN_STEP_W   = 4,
    parameter int unsigned DN_STEP_VAL = 1,
    parameter lim_mode_e   UP_LIM_MODE = LIM_EDGE,
    parameter int unsigned UP_LIM_VAL  = (1 << WIDTH) - 1,
    parameter lim_mode_e   DN_LIM_MODE = LIM_EDGE,
    parameter int unsigned DN_LIM_VAL  = 0,
    parameter src_sel_e    UP_THR_SRC  = SRC_FIXED,
    parameter int unsigned UP_THR_VAL  = (1 << WIDTH) - 1,
    parameter src_sel_e    DN_THR_SRC  = SRC_FIXED,
    parameter int unsigned DN_THR_VAL  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 up_pulse,
    input  logic [UP_STEP_W-1:0] up_step,
    input  logic                 dn_pulse,
    input  logic [DN_STEP_W-1:0] dn_step,
    input  logic [WIDTH-1:0]     up_limit,
    input  logic [WIDTH-1:0]     dn_limit,
    input  logic [WIDTH-1:0]     up_thresh,
    input  logic [WIDTH-1:0]     dn_thresh,
    input  logic                 sw_we,
    input  logic [WIDTH-1:0]     sw_wdata,
    output logic [WIDTH-1:0]     count,
    output logic                 at_or_above,
    output logic                 at_or_below,
    output logic                 overflow,
    underflow
);
    localparam int unsigned MAXV       = (1 << WIDTH) - 1;
    localparam src_sel_e    HI_SRC     = src_sel_e'((UP_LIM_MODE == LIM_PORT) ? SRC_PORT : SRC_FIXED);
    localparam src_sel_e    LO_SRC     = src_sel_e'((DN_LIM_MODE == LIM_PORT) ? SRC_PORT : SRC_FIXED);
    localparam int unsigned HI_CONST   = (UP_LIM_MODE == LIM_FIXED) ? UP_LIM_VAL : MAXV;
    localparam int unsigned LO_CONST   = (DN_LIM_MODE == LIM_FIXED) ? DN_LIM_VAL : 0;

    logic [WIDTH-1:0] up_sel, dn_sel, hi_sel, lo_sel, uthr_sel, dthr_sel;
    logic [WIDTH-1:0] up_amt, dn_amt, nxt;

    ctrfld_src_sel #(.W(WIDTH), .PW(UP_STEP_W), .SRC(UP_STEP_SRC), .FIXED_VAL(UP_STEP_VAL))
        u_up_step (.port_val(up_step), .sel_val(up_sel));
    ctrfld_src_sel #(.W(WIDTH), .PW(DN_STEP_W), .SRC(DN_STEP_SRC), .FIXED_VAL(DN_STEP_VAL))
        u_dn_step (.port_val(dn_step), .sel_val(dn_sel));
    ctrfld_src_sel #(.W(WIDTH), .PW(WIDTH), .SRC(HI_SRC), .FIXED_VAL(HI_CONST))
        u_hi_lim (.port_val(up_limit), .sel_val(hi_sel));
    ctrfld_src_sel #(.W(WIDTH), .PW(WIDTH), .SRC(LO_SRC), .FIXED_VAL(LO_CONST))
        u_lo_lim (.port_val(dn_limit), .sel_val(lo_sel));
    ctrfld_src_sel #(.W(WIDTH), .PW(WIDTH), .SRC(UP_THR_SRC), .FIXED_VAL(UP_THR_VAL))
        u_up_thr (.port_val(up_thresh), .sel_val(uthr_sel));
    ctrfld_src_sel #(.W(WIDTH), .PW(WIDTH), .SRC(DN_THR_SRC), .FIXED_VAL(DN_THR_VAL))
        u_dn_thr (.port_val(dn_thresh), .sel_val(dthr_sel));

    // Gate the steps with their pulses; decrement is gated off entirely when disabled.
    assign up_amt = up_pulse ? up_sel : '0;
    assign dn_amt = (DN_ENABLE && dn_pulse) ? dn_sel : '0;

    ctrfld_next #(.WIDTH(WIDTH), .UP_MODE(UP_LIM_MODE), .DN_MODE(DN_LIM_MODE)) u_next (
        .cur     (count),
        .up_amt  (up_amt),
        .dn_amt  (dn_amt),
        .hi_lim  (hi_sel),
        .lo_lim  (lo_sel),
        .wr_en   (sw_we),
        .wr_data (sw_wdata),
        .nxt     (nxt),
        .wrap_up (overflow),
        .wrap_dn (underflow)
    );

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= WIDTH'(RST_VAL);
        else        count <= nxt;
    end

    // Threshold flags follow the registered count.
    assign at_or_above = (count >= uthr_sel);
    assign at_or_below = (count <= dthr_sel);
endmodule

// File: rtl/ctrfld_counter_chk.sv
// Property checker for ctrfld_counter, attached through the bind below.
// It rebuilds the effective limits from the parameters and ports on its own.
module ctrfld_counter_chk
    import ctrfld_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter lim_mode_e   UP_LIM_MODE = LIM_EDGE,
    parameter int unsigned UP_LIM_VAL  = (1 << WIDTH) - 1,
    parameter lim_mode_e   DN_LIM_MODE = LIM_EDGE,
    parameter int unsigned DN_LIM_VAL  = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_pulse,
    input logic             dn_pulse,
    input logic [WIDTH-1:0] up_limit,
    input logic [WIDTH-1:0] dn_limit,
    input logic             sw_we,
    input logic [WIDTH-1:0] sw_wdata,
    input logic [WIDTH-1:0] count,
    input logic             overflow,
    input logic             underflow
);
    logic [WIDTH-1:0] hi_eff, lo_eff;
    logic             lims_ok;

    // Effective limits as seen from the parameters and ports.
    always_comb begin
        case (UP_LIM_MODE)
            LIM_PORT:  hi_eff = up_limit;
            LIM_FIXED: hi_eff = WIDTH'(UP_LIM_VAL);
            default:   hi_eff = '1;
        endcase
        case (DN_LIM_MODE)
            LIM_PORT:  lo_eff = dn_limit;
            LIM_FIXED: lo_eff = WIDTH'(DN_LIM_VAL);
            default:   lo_eff = '0;
        endcase
        lims_ok = (lo_eff <= hi_eff);
    end

    p_hi_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((UP_LIM_MODE != LIM_WRAP) && lims_ok) |=> (count <= $past(hi_eff)));

    p_lo_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (DN_LIM_MODE != LIM_WRAP) |=> (count >= $past(lo_eff)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (UP_LIM_MODE != LIM_WRAP) |-> !overflow);

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (DN_LIM_MODE != LIM_WRAP) |-> !underflow);

    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (up_pulse && !sw_we));

    p_unf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (dn_pulse && !sw_we));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && (sw_wdata >= lo_eff) && (sw_wdata <= hi_eff)) |=> (count == $past(sw_wdata)));
endmodule

bind ctrfld_counter ctrfld_counter_chk #(
    .WIDTH       (WIDTH),
    .UP_LIM_MODE (UP_LIM_MODE),
    .UP_LIM_VAL  (UP_LIM_VAL),
    .DN_LIM_MODE (DN_LIM_MODE),
    .DN_LIM_VAL  (DN_LIM_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_pulse  (up_pulse),
    .dn_pulse  (dn_pulse),
    .up_limit  (up_limit),
    .dn_limit  (dn_limit),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .count     (count),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/tb_ctrfld_counter.sv
`timescale 1ns/1ps
module tb_ctrfld_counter;
    import ctrfld_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_pulse = 1'b0, dn_pulse = 1'b0, sw_we = 1'b0;
    logic [3:0] up_step = 4'd0, dn_step = 4'd0;
    logic [7:0] up_limit = 8'd250, dn_limit = 8'd0, up_thresh = 8'd0, dn_thresh = 8'd12;
    logic [7:0] sw_wdata = 8'd0;

    logic [7:0] c_main, c_wrap, c_up;
    logic ge_main, le_main, ov_main, un_main;
    logic ge_wrap, le_wrap, ov_wrap, un_wrap;
    logic ge_up, le_up, ov_up, un_up;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    // Main config: port limit up, fixed 4 down, port up step, fixed 3 down step.
    ctrfld_counter #(.WIDTH(8), .RST_VAL(10), .UP_STEP_SRC(SRC_PORT), .UP_STEP_W(4),
        .DN_STEP_VAL(3), .UP_LIM_MODE(LIM_PORT), .DN_LIM_MODE(LIM_FIXED), .DN_LIM_VAL(4),
        .UP_THR_VAL(200), .DN_THR_SRC(SRC_PORT)) dut (
        .clk(clk), .rst_n(rst_n), .up_pulse(up_pulse), .up_step(up_step),
        .dn_pulse(dn_pulse), .dn_step(dn_step), .up_limit(up_limit), .dn_limit(dn_limit),
        .up_thresh(up_thresh), .dn_thresh(dn_thresh), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .count(c_main), .at_or_above(ge_main), .at_or_below(le_main),
        .overflow(ov_main), .underflow(un_main));

    // Wrapping config: fixed up step 5, port down step, default thresholds.
    ctrfld_counter #(.WIDTH(8), .UP_STEP_VAL(5), .DN_STEP_SRC(SRC_PORT),
        .UP_LIM_MODE(LIM_WRAP), .DN_LIM_MODE(LIM_WRAP)) dut_wrap (
        .clk(clk), .rst_n(rst_n), .up_pulse(up_pulse), .up_step(up_step),
        .dn_pulse(dn_pulse), .dn_step(dn_step), .up_limit(up_limit), .dn_limit(dn_limit),
        .up_thresh(up_thresh), .dn_thresh(dn_thresh), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .count(c_wrap), .at_or_above(ge_wrap), .at_or_below(le_wrap),
        .overflow(ov_wrap), .underflow(un_wrap));

    // Up-only config: fixed limit 100, step 7, decrement disabled.
    ctrfld_counter #(.WIDTH(8), .DN_ENABLE(1'b0), .UP_STEP_VAL(7),
        .UP_LIM_MODE(LIM_FIXED), .UP_LIM_VAL(100)) dut_up (
        .clk(clk), .rst_n(rst_n), .up_pulse(up_pulse), .up_step(up_step),
        .dn_pulse(dn_pulse), .dn_step(dn_step), .up_limit(up_limit), .dn_limit(dn_limit),
        .up_thresh(up_thresh), .dn_thresh(dn_thresh), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .count(c_up), .at_or_above(ge_up), .at_or_below(le_up),
        .overflow(ov_up), .underflow(un_up));

    typedef struct packed {
        logic       sw;
        logic [7:0] wd;
        logic       up;
        logic [3:0] us;
        logic       dn;
        logic [7:0] ulim;
        logic [7:0] ev;
        logic       ge;
        logic       le;
        logic [3:0] rq;
    } vec_t;

    // Vectors for the main config, starting from reset value 10.
    localparam vec_t TBL [13] = '{
        '{1'b0, 8'd0,   1'b1, 4'd5,  1'b0, 8'd250, 8'd15,  1'b0, 1'b0, 4'd2},  // R2 up
        '{1'b0, 8'd0,   1'b0, 4'd0,  1'b1, 8'd250, 8'd12,  1'b0, 1'b1, 4'd2},  // R2 down
        '{1'b0, 8'd0,   1'b1, 4'd7,  1'b1, 8'd250, 8'd16,  1'b0, 1'b0, 4'd8},  // R8 net
        '{1'b1, 8'd198, 1'b0, 4'd0,  1'b0, 8'd250, 8'd198, 1'b0, 1'b0, 4'd9},  // R9 write
        '{1'b0, 8'd0,   1'b1, 4'd2,  1'b0, 8'd250, 8'd200, 1'b1, 1'b0, 4'd10}, // R10 edge
        '{1'b0, 8'd0,   1'b1, 4'd15, 1'b0, 8'd250, 8'd215, 1'b1, 1'b0, 4'd2},  // R2 max step
        '{1'b1, 8'd255, 1'b0, 4'd0,  1'b0, 8'd250, 8'd250, 1'b1, 1'b0, 4'd7},  // R7 write clamp
        '{1'b0, 8'd0,   1'b1, 4'd9,  1'b0, 8'd250, 8'd250, 1'b1, 1'b0, 4'd5},  // R5 saturate
        '{1'b1, 8'd5,   1'b0, 4'd0,  1'b0, 8'd250, 8'd5,   1'b0, 1'b1, 4'd9},  // R9 write
        '{1'b0, 8'd0,   1'b0, 4'd0,  1'b1, 8'd250, 8'd4,   1'b0, 1'b1, 4'd6},  // R6 saturate
        '{1'b1, 8'd1,   1'b0, 4'd0,  1'b0, 8'd250, 8'd4,   1'b0, 1'b1, 4'd7},  // R7 write clamp
        '{1'b1, 8'd100, 1'b1, 4'd9,  1'b1, 8'd250, 8'd100, 1'b0, 1'b0, 4'd9},  // R9 precedence
        '{1'b0, 8'd0,   1'b0, 4'd0,  1'b0, 8'd60,  8'd60,  1'b0, 1'b0, 4'd7}   // R7 port limit
    };

    // Compare and count one check.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge and let it settle.
    task automatic apply(input logic w, input logic [7:0] d, input logic u,
                         input logic dn, input logic [3:0] ds);
        @(negedge clk);
        sw_we = w; sw_wdata = d; up_pulse = u; dn_pulse = dn; dn_step = ds;
        #1;
    endtask

    task automatic idle();
        sw_we = 1'b0; up_pulse = 1'b0; dn_pulse = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset main", c_main, 10);
        chk("R1 reset wrap", c_wrap, 0);
        rst_n = 1'b1;

        // Vector walk over the main config.
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            sw_we = TBL[i].sw; sw_wdata = TBL[i].wd; up_pulse = TBL[i].up;
            up_step = TBL[i].us; dn_pulse = TBL[i].dn; up_limit = TBL[i].ulim;
            #1;
            chk("R5 no overflow main", ov_main, 0);
            chk("R6 no underflow main", un_main, 0);
            @(negedge clk);
            chk($sformatf("R%0d row %0d count", TBL[i].rq, i), c_main, TBL[i].ev);
            chk($sformatf("R10 row %0d flag", i), ge_main, TBL[i].ge);
            chk($sformatf("R11 row %0d flag", i), le_main, TBL[i].le);
            idle();
        end
        up_limit = 8'd250; up_step = 4'd1;

        // D1: write beyond the fixed limit of the up-only config.
        apply(1'b1, 8'd253, 1'b0, 1'b0, 4'd0);
        @(negedge clk); idle();
        chk("R5 fixed clamp dut_up", c_up, 100);
        chk("R9 write dut_wrap", c_wrap, 253);

        // D2: increment across the wrap point.
        apply(1'b0, 8'd0, 1'b1, 1'b0, 4'd0);
        chk("R3 overflow asserted", ov_wrap, 1);
        chk("R5 overflow quiet dut_up", ov_up, 0);
        @(negedge clk); idle();
        chk("R3 wrapped value", c_wrap, 2);
        chk("R5 held at limit", c_up, 100);

        // D3: decrement across zero.
        apply(1'b0, 8'd0, 1'b0, 1'b1, 4'd6);
        chk("R4 underflow asserted", un_wrap, 1);
        chk("R3 overflow quiet on decrement", ov_wrap, 0);
        @(negedge clk); idle();
        chk("R4 wrapped value", c_wrap, 252);

        // D4: decrement ignored when disabled.
        apply(1'b1, 8'd50, 1'b0, 1'b0, 4'd0);
        @(negedge clk); idle();
        apply(1'b0, 8'd0, 1'b0, 1'b1, 4'd6);
        chk("R12 no underflow dut_up", un_up, 0);
        chk("R4 no underflow above zero", un_wrap, 0);
        @(negedge clk); idle();
        chk("R12 count unchanged", c_up, 50);
        chk("R2 port step down", c_wrap, 44);

        // D5: simultaneous pulses whose net crosses zero.
        apply(1'b1, 8'd2, 1'b0, 1'b0, 4'd0);
        @(negedge clk); idle();
        apply(1'b0, 8'd0, 1'b1, 1'b1, 4'd9);
        chk("R8 net underflow", un_wrap, 1);
        chk("R8 no overflow on net", ov_wrap, 0);
        @(negedge clk); idle();
        chk("R8 net wrapped value", c_wrap, 254);

        // D6: default thresholds of the wrapping config.
        apply(1'b1, 8'd0, 1'b0, 1'b0, 4'd0);
        @(negedge clk); idle();
        chk("R11 default low threshold", le_wrap, 1);
        chk("R10 below default high", ge_wrap, 0);
        apply(1'b1, 8'd255, 1'b0, 1'b0, 4'd0);
        @(negedge clk); idle();
        chk("R10 default high threshold", ge_wrap, 1);
        chk("R11 above default low", le_wrap, 0);

        // D7: reset in mid-run.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset main", c_main, 10);
        chk("R1 mid-run reset wrap", c_wrap, 0);
        chk("R1 mid-run reset up", c_up, 0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule